// File: doc/BRIEF.md
# Coalescing Interrupt Source State Bank

This block keeps a two-bit state for each interrupt source in a bank. One bit is the pending flag P: an event for the source has gone to a queue and is waiting for end-of-interrupt (EOI). The other bit is the queued-again flag Q: the source fired again while P was set. The state machine coalesces triggers, so no more than one event per source is ever in a queue. A hardware trigger port advances the state of one source per cycle. It emits an event only when the source goes from idle to pending.

Software reaches the state through a small memory-mapped slave port. Each source owns a 4 KiB page, and the address is `{source index, page offset}`. The page offset selects the operation. Every load returns the state that held before the access, and the read and the update happen in one step. A load at the EOI offset returns the Q flag, so software knows whether the event has been replayed. The block emits events on two registered lanes. The trigger lane carries fresh events from the hardware trigger. The EOI lane carries replays caused by an EOI that finds Q set.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source state is 00. While reset is held, `mmio_rvalid`, `evt_trg_valid` and `evt_eoi_valid` are low.
- R2: A trigger on an in-range source in state 00 moves that source to 10. One cycle later it raises `evt_trg_valid` for one cycle, with `evt_trg_src` equal to the triggered index.
- R3: A trigger on a source in state 10 or 11 leaves the source at 11 and emits no event. A trigger on a source in state 01 (masked) changes nothing. A trigger whose index is at or above NUM_SRC changes nothing.
- R4: A load at page offset 0x800 returns the prior state in `mmio_rdata[1:0]`, with P in bit 1 and Q in bit 0 and the upper bits zero. The state is left unchanged.
- R5: A load at page offset 0xC00, 0xD00, 0xE00 or 0xF00 returns the prior state in the R4 layout. It then sets the state to offset bits [9:8], which give 00, 01, 10 and 11 in turn.
- R6: A load at page offset 0x000 performs EOI and returns 0x01 if Q was set, otherwise 0x00. EOI moves 10 to 00 and leaves 00 and 01 unchanged. It moves 11 to 10 and, one cycle later, raises `evt_eoi_valid` with `evt_eoi_src` equal to the source index.
- R7: A store at page offset 0x400 performs the R6 state change and replay event but gives no read response. A store at any other offset changes nothing.
- R8: Address bit 6 (offset 0x40, the ordering hint) plays no part in selecting the operation.
- R9: A load at any other offset, or to a source index at or above NUM_SRC, returns 0xFF and changes no state.
- R10: When an access and a trigger hit the same source in one cycle, the access is applied first. The trigger is then evaluated on the state the access leaves behind.
- R11: `mmio_rvalid` is high for exactly one cycle, in the cycle after each load request. It stays low after stores and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_req | input | 1 | Access request, one access per cycle |
| mmio_wr | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | IDX_W+12 | Source index in the upper bits, page offset in bits [11:0] |
| mmio_rvalid | output | 1 | Load response valid |
| mmio_rdata | output | 8 | Load response data |
| trig_valid | input | 1 | Hardware trigger strobe |
| trig_src | input | IDX_W | Source index of the trigger |
| evt_trg_valid | output | 1 | Fresh event from a trigger |
| evt_trg_src | output | IDX_W | Source index of the fresh event |
| evt_eoi_valid | output | 1 | Replayed event from an EOI that found Q set |
| evt_eoi_src | output | IDX_W | Source index of the replayed event |

## Verification
The assertions assume that `mmio_req`, `mmio_wr`, `mmio_addr`, `trig_valid` and `trig_src` are held at known values while reset is asserted. They also assume that a single access and a single trigger at most arrive per cycle, which the port widths already enforce. The bench drives all inputs at the falling edge and holds them at zero during reset. Its random stimulus picks source indices across the whole index field, including the range above NUM_SRC. It also makes the access and the trigger name the same source often enough to exercise R10 many times.

// File: rtl/pq_pkg.sv
package pq_pkg;

  localparam int PAGE_W    = 12;
  localparam int ORDER_BIT = 6;

  typedef logic [1:0] pq_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_BAD
  } op_e;

  // Operation selected by a page offset, ordering hint masked out.
  function automatic op_e decode_offset(logic wr, logic [PAGE_W-1:0] off,
                                        logic st_eoi_en);
    logic [PAGE_W-1:0] m;
    op_e r;
    m = off & ~(PAGE_W'(1) << ORDER_BIT);
    if (wr) begin
      r = (st_eoi_en && m == 12'h400) ? OP_EOI : OP_NONE;
    end else begin
      case (m)
        12'h000:                            r = OP_EOI;
        12'h800:                            r = OP_GET;
        12'hC00, 12'hD00, 12'hE00, 12'hF00: r = OP_SET;
        default:                            r = OP_BAD;
      endcase
    end
    return r;
  endfunction

  function automatic pq_t trig_next(pq_t s);
    case (s)
      2'b00:   return 2'b10;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic trig_fires(pq_t s);
    return s == 2'b00;
  endfunction

  function automatic pq_t eoi_next(pq_t s);
    case (s)
      2'b10:   return 2'b00;
      2'b11:   return 2'b10;
      default: return s;
    endcase
  endfunction

  function automatic logic eoi_fires(pq_t s);
    return s == 2'b11;
  endfunction

  function automatic pq_t access_next(op_e op, pq_t s, pq_t set_val);
    case (op)
      OP_EOI:  return eoi_next(s);
      OP_SET:  return set_val;
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] load_result(op_e op, pq_t s);
    case (op)
      OP_EOI:         return {7'b0, s[0]};
      OP_GET, OP_SET: return {6'b0, s};
      default:        return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
  import pq_pkg::*;
#(
  parameter int   NUM_SRC      = 12,
  parameter int   IDX_W        = 4,
  parameter logic STORE_EOI_EN = 1'b1,
  localparam int  ADDR_W       = IDX_W + PAGE_W
) (
  input  logic              mmio_req,
  input  logic              mmio_wr,
  input  logic [ADDR_W-1:0] mmio_addr,
  output op_e               op,
  output logic [IDX_W-1:0]  src,
  output pq_t               set_val
);

  logic              in_range;
  logic [PAGE_W-1:0] off;
  op_e               raw_op;

  assign src      = mmio_addr[ADDR_W-1:PAGE_W];
  assign off      = mmio_addr[PAGE_W-1:0];
  assign in_range = int'(src) < NUM_SRC;
  assign set_val  = off[9:8];
  assign raw_op   = decode_offset(mmio_wr, off, STORE_EOI_EN);

  always_comb begin
    if (!mmio_req)     op = OP_NONE;
    else if (in_range) op = raw_op;
    else               op = mmio_wr ? OP_NONE : OP_BAD;
  end

endmodule

// File: rtl/pq_state_bank.sv
module pq_state_bank
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              mmio_op,
  input  logic [IDX_W-1:0] mmio_src,
  input  pq_t              set_val,
  input  logic             trig_valid,
  input  logic [IDX_W-1:0] trig_src,
  output pq_t              mmio_old,
  output logic             eoi_fire,
  output logic             trg_fire
);

  pq_t  state_q [NUM_SRC];
  pq_t  state_d [NUM_SRC];
  pq_t  mmio_new;
  pq_t  trig_base;
  logic mmio_live;
  logic trig_in_range;

  assign mmio_live     = (mmio_op == OP_EOI) || (mmio_op == OP_GET) || (mmio_op == OP_SET);
  assign trig_in_range = int'(trig_src) < NUM_SRC;

  always_comb begin
    mmio_old = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (mmio_src == IDX_W'(i)) mmio_old = state_q[i];
  end

  assign mmio_new = access_next(mmio_op, mmio_old, set_val);

  // Trigger sees the post-access state when both name one source.
  always_comb begin
    trig_base = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (trig_src == IDX_W'(i)) trig_base = state_q[i];
    if (mmio_live && mmio_src == trig_src) trig_base = mmio_new;
  end

  assign eoi_fire = (mmio_op == OP_EOI) && eoi_fires(mmio_old);
  assign trg_fire = trig_valid && trig_in_range && trig_fires(trig_base);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pq_t after_acc;
    assign after_acc  = (mmio_live && mmio_src == IDX_W'(g)) ? mmio_new : state_q[g];
    assign state_d[g] = (trig_valid && trig_src == IDX_W'(g)) ? trig_next(after_acc)
                                                               : after_acc;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rst_n) state_q[i] <= '0;
      else        state_q[i] <= state_d[i];
    end
  end

endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
  import pq_pkg::*;
#(
  parameter int   NUM_SRC      = 12,
  parameter int   IDX_W        = 4,
  parameter logic STORE_EOI_EN = 1'b1,
  localparam int  ADDR_W       = IDX_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_req,
  input  logic              mmio_wr,
  input  logic [ADDR_W-1:0] mmio_addr,
  output logic              mmio_rvalid,
  output logic [7:0]        mmio_rdata,
  input  logic              trig_valid,
  input  logic [IDX_W-1:0]  trig_src,
  output logic              evt_trg_valid,
  output logic [IDX_W-1:0]  evt_trg_src,
  output logic              evt_eoi_valid,
  output logic [IDX_W-1:0]  evt_eoi_src
);

  op_e              dec_op;
  logic [IDX_W-1:0] dec_src;
  pq_t              dec_set;
  pq_t              old_pq;
  logic             eoi_fire_w;
  logic             trg_fire_w;

  pq_addr_decode #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .STORE_EOI_EN(STORE_EOI_EN)
  ) u_dec (
    .mmio_req (mmio_req),
    .mmio_wr  (mmio_wr),
    .mmio_addr(mmio_addr),
    .op       (dec_op),
    .src      (dec_src),
    .set_val  (dec_set)
  );

  pq_state_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .mmio_op   (dec_op),
    .mmio_src  (dec_src),
    .set_val   (dec_set),
    .trig_valid(trig_valid),
    .trig_src  (trig_src),
    .mmio_old  (old_pq),
    .eoi_fire  (eoi_fire_w),
    .trg_fire  (trg_fire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mmio_rvalid   <= 1'b0;
      mmio_rdata    <= '0;
      evt_trg_valid <= 1'b0;
      evt_trg_src   <= '0;
      evt_eoi_valid <= 1'b0;
      evt_eoi_src   <= '0;
    end else begin
      mmio_rvalid   <= mmio_req && !mmio_wr;
      mmio_rdata    <= load_result(dec_op, old_pq);
      evt_trg_valid <= trg_fire_w;
      evt_trg_src   <= trig_src;
      evt_eoi_valid <= eoi_fire_w;
      evt_eoi_src   <= dec_src;
    end
  end

endmodule

// File: rtl/pq_source_bank_chk.sv
module pq_source_bank_chk #(
  parameter int  NUM_SRC = 12,
  parameter int  IDX_W   = 4,
  localparam int ADDR_W  = IDX_W + 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mmio_req,
  input logic              mmio_wr,
  input logic [ADDR_W-1:0] mmio_addr,
  input logic              mmio_rvalid,
  input logic [7:0]        mmio_rdata,
  input logic              trig_valid,
  input logic [IDX_W-1:0]  trig_src,
  input logic              evt_trg_valid,
  input logic [IDX_W-1:0]  evt_trg_src,
  input logic              evt_eoi_valid,
  input logic [IDX_W-1:0]  evt_eoi_src,
  input logic              eoi_fire_w,
  input logic              trg_fire_w
);

  logic load_req;
  logic load_oob;
  assign load_req = mmio_req && !mmio_wr;
  assign load_oob = load_req && (int'(mmio_addr[ADDR_W-1:12]) >= NUM_SRC);

  // R11
  load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> mmio_rvalid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> !mmio_rvalid);

  // R2
  trg_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trg_fire_w |=> (evt_trg_valid && evt_trg_src == $past(trig_src)));

  // R2
  trg_evt_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trg_fire_w |-> trig_valid);

  // R6
  eoi_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire_w |=> (evt_eoi_valid && evt_eoi_src == $past(mmio_addr[ADDR_W-1:12])));

  // R6
  eoi_evt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire_w |-> mmio_req);

  // R9
  oob_load_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_oob |=> mmio_rdata == 8'hFF);

  // R4
  rdata_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_rvalid && mmio_rdata != 8'hFF) |-> mmio_rdata[7:2] == 6'b0);

  // R10
  one_evt_per_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_trg_valid && evt_eoi_valid) |-> evt_trg_src != evt_eoi_src);

endmodule

bind pq_source_bank pq_source_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_pq_source_bank.sv
module tb_pq_source_bank;

  localparam int NS = 12;
  localparam int IW = 4;
  localparam int AW = IW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mmio_req = 1'b0;
  logic          mmio_wr = 1'b0;
  logic [AW-1:0] mmio_addr = '0;
  logic          mmio_rvalid;
  logic [7:0]    mmio_rdata;
  logic          trig_valid = 1'b0;
  logic [IW-1:0] trig_src = '0;
  logic          evt_trg_valid;
  logic [IW-1:0] evt_trg_src;
  logic          evt_eoi_valid;
  logic [IW-1:0] evt_eoi_src;

  pq_source_bank #(.NUM_SRC(NS), .IDX_W(IW)) dut (.*);

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [1:0] m [NS];
  bit         armed = 1'b0;
  logic       e_rv;
  logic [7:0] e_rd;
  logic       e_tv;
  logic [IW-1:0] e_ts;
  logic       e_ev;
  logic [IW-1:0] e_es;
  string      l_rd, l_t, l_e;
  string      lab_override = "";

  task automatic chk(string lab, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", lab, what, act, exp);
    end
  endtask

  task automatic model_eoi(int idx, output bit fire);
    fire = 1'b0;
    if (m[idx] == 2'b11) begin m[idx] = 2'b10; fire = 1'b1; end
    else if (m[idx] == 2'b10) m[idx] = 2'b00;
  endtask

  task automatic compare_outputs();
    chk("R11", "rvalid", int'(mmio_rvalid), int'(e_rv));
    if (e_rv) chk(l_rd, "rdata", int'(mmio_rdata), int'(e_rd));
    chk(l_t, "trg_valid", int'(evt_trg_valid), int'(e_tv));
    if (e_tv) chk(l_t, "trg_src", int'(evt_trg_src), int'(e_ts));
    chk(l_e, "eoi_valid", int'(evt_eoi_valid), int'(e_ev));
    if (e_ev) chk(l_e, "eoi_src", int'(evt_eoi_src), int'(e_es));
  endtask

  task automatic step(bit req, bit wr, logic [AW-1:0] addr, bit tv, logic [IW-1:0] ts);
    int idx;
    logic [11:0] off;
    bit fire;
    @(negedge clk);
    if (armed) compare_outputs();
    mmio_req = req; mmio_wr = wr; mmio_addr = addr;
    trig_valid = tv; trig_src = ts;
    idx = int'(addr[AW-1:12]);
    off = addr[11:0] & 12'hFBF;
    e_rv = req && !wr; e_rd = 8'h00; e_tv = 1'b0; e_ts = ts;
    e_ev = 1'b0; e_es = addr[AW-1:12];
    l_rd = "R4"; l_t = "R2"; l_e = "R6";
    if (req && !wr) begin
      if (idx >= NS) begin e_rd = 8'hFF; l_rd = "R9"; end
      else begin
        case (off)
          12'h000: begin
            e_rd = {7'b0, m[idx][0]}; l_rd = "R6";
            model_eoi(idx, fire); e_ev = fire;
          end
          12'h800: begin e_rd = {6'b0, m[idx]}; l_rd = "R4"; end
          12'hC00, 12'hD00, 12'hE00, 12'hF00: begin
            e_rd = {6'b0, m[idx]}; l_rd = "R5"; m[idx] = off[9:8];
          end
          default: begin e_rd = 8'hFF; l_rd = "R9"; end
        endcase
      end
      if (addr[6]) l_rd = "R8";
    end else if (req && wr && idx < NS && off == 12'h400) begin
      model_eoi(idx, fire); e_ev = fire; l_e = "R7";
    end
    if (tv && int'(ts) < NS) begin
      if (req && idx == int'(ts)) l_t = "R10";
      case (m[ts])
        2'b00: begin m[ts] = 2'b10; e_tv = 1'b1; end
        2'b01: ;
        default: m[ts] = 2'b11;
      endcase
    end else if (tv) l_t = "R3";
    if (lab_override != "") begin l_rd = lab_override; l_t = lab_override; end
    armed = 1'b1;
  endtask

  function automatic logic [AW-1:0] A(int idx, int off);
    return {IW'(idx), 12'(off)};
  endfunction

  task automatic ld(int idx, int off);
    step(1'b1, 1'b0, A(idx, off), 1'b0, '0);
  endtask

  task automatic trg(int idx);
    step(1'b0, 1'b0, '0, 1'b1, IW'(idx));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NS; i++) m[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "rvalid in reset", int'(mmio_rvalid), 0);
    chk("R1", "trg in reset", int'(evt_trg_valid), 0);
    chk("R1", "eoi in reset", int'(evt_eoi_valid), 0);
    rst_n = 1'b1;

    // R1: every state reads 00 after reset
    lab_override = "R1";
    for (int i = 0; i < NS; i++) ld(i, 12'h800);
    lab_override = "";

    // R2, R3, R6: trigger, coalesce, EOI replay
    trg(3); trg(3); ld(3, 12'h800);
    ld(3, 12'h000); ld(3, 12'h000); ld(3, 12'h000); ld(3, 12'h800);
    // R3: masked source, out-of-range trigger
    ld(5, 12'hD00); trg(5); ld(5, 12'h800);
    trg(14); trg(15);
    // R5: each set value
    ld(6, 12'hC00); ld(6, 12'hE00); ld(6, 12'hF00); ld(6, 12'hD00); ld(6, 12'h800);
    // R7: store EOI and ignored store
    trg(2); trg(2);
    step(1'b1, 1'b1, A(2, 12'h400), 1'b0, '0);
    step(1'b1, 1'b1, A(2, 12'h800), 1'b0, '0);
    step(1'b1, 1'b1, A(2, 12'h400), 1'b0, '0);
    ld(2, 12'h800);
    // R8: ordering hint ignored
    ld(6, 12'hC40); ld(6, 12'hF40); ld(6, 12'h840); ld(6, 12'h040); ld(6, 12'h840);
    // R9: unused offset, out-of-range source
    ld(4, 12'h100); ld(4, 12'h400); ld(13, 12'h800); ld(15, 12'hF00); ld(4, 12'h800);
    // R10: same-cycle access and trigger on one source
    step(1'b1, 1'b0, A(7, 12'hC00), 1'b1, IW'(7));
    step(1'b1, 1'b0, A(7, 12'hF00), 1'b1, IW'(7));
    step(1'b1, 1'b0, A(7, 12'h000), 1'b1, IW'(7));
    step(1'b1, 1'b0, A(7, 12'hD00), 1'b1, IW'(7));
    ld(7, 12'h800);

    // random mix
    for (int n = 0; n < 5000; n++) begin
      int idx, sel, off, tsrc;
      bit wr, req, tv;
      idx  = $urandom_range(0, 15);
      sel  = $urandom_range(0, 9);
      case (sel)
        0: off = 12'h000; 1: off = 12'h800; 2: off = 12'hC00; 3: off = 12'hD00;
        4: off = 12'hE00; 5: off = 12'hF00; 6: off = 12'h400; 7: off = 12'h000;
        8: off = 12'h200; default: off = 12'h800;
      endcase
      if ($urandom_range(0, 3) == 0) off = off | 12'h040;
      req  = $urandom_range(0, 3) != 0;
      wr   = $urandom_range(0, 4) == 0;
      tv   = $urandom_range(0, 1) == 1;
      tsrc = ($urandom_range(0, 2) == 0) ? idx : $urandom_range(0, 15);
      step(req, wr, A(idx, off), tv, IW'(tsrc));
    end
    step(1'b0, 1'b0, '0, 1'b0, '0);
    step(1'b0, 1'b0, '0, 1'b0, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule